// File: doc/BRIEF.md
# Clock Output Stop and Enable Controller

This block decides, for every clock output of a clock generator, whether that output toggles, is parked at a driven stopped level, or is released to high impedance. The outputs are three CPU differential pairs, six SRC differential pairs, two SRCS differential pairs and three single-ended outputs (REF, PCI and USB). Each output has its own enable bit. Each CPU pair can opt in to the CPU stop pin. Each SRC pair has one opt-in mask for each of the two CLKREQ# pins. Separate mode bits decide whether a stop event or a power-down parks the output driven or tri-stated. The clock synthesis and the pad drivers sit outside the block.

Each output supplies a one-cycle tick that marks its own clock-low boundary. The run and output-enable results of an output change only on that tick, so the block never cuts a pulse short. The stop pins are asynchronous and pass through a two-flop synchronizer before they are used. A CPU stop counts two ticks of the affected output before that output halts. When `out_run` is 0 and `out_oe` is 1 on a differential pair, the pad holds true high and complement low. On a single-ended output it holds the line low.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: After reset and before the first tick of an output, that output has `out_run`=0 and `out_oe`=0.
- R2: An enabled output with no stop and no power-down active gets `out_run`=1 and `out_oe`=1 at its next tick. `out_run`=1 never occurs with `out_oe`=0.
- R3: `out_run[i]` and `out_oe[i]` change only at a clock edge where `out_tick[i]` is 1. At every other edge they hold their value.
- R4: A disabled differential output goes to `out_run`=0 and `out_oe`=0. A disabled single-ended output goes to `out_run`=0 and `out_oe`=1 (held low).
- R5: Once the synchronized CPU stop is active, a stoppable CPU output keeps running through its first tick and halts at its second tick.
- R6: A CPU pair whose `cpu_stop_mask` bit is 0 keeps running while the CPU stop pin is asserted.
- R7: A stopped CPU pair is driven (`out_oe`=1) when `cpu_stop_tri`=0 and tri-stated when `cpu_stop_tri`=1.
- R8: SRC pair i stops when (`src_req0_mask[i]` and `clkreq_n[0]`=1) or (`src_req1_mask[i]` and `clkreq_n[1]`=1). Unmasked SRC pairs, the SRCS pairs and the single-ended outputs ignore both CLKREQ# pins.
- R9: A stopped SRC pair is tri-stated when `req_tri`=1 and driven when `req_tri`=0.
- R10: After a stop pin is released and the release has passed the synchronizer, the output runs again at its next tick, with no added delay.
- R11: While `pd_req`=1 every output halts at its tick. CPU pairs get `out_oe`=!`cpu_pd_tri`, SRC and SRCS pairs get `out_oe`=!`src_pd_tri`, and single-ended outputs stay driven.
- R12: Power-down takes priority over the stop pins, and an active stop takes priority over the enable bit. This covers both the run decision and the drive mode.
- R13: A stop pin passes two flops before it is used. A change at the pin is not seen by a tick at the first clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_en | input | N_CPU | Enable bit for each CPU pair |
| cpu_stop_mask | input | N_CPU | 1 = the CPU pair obeys the CPU stop pin |
| cpu_stop_tri | input | 1 | 1 = CPU pairs halted by a stop are tri-stated |
| cpu_pd_tri | input | 1 | 1 = CPU pairs are tri-stated in power-down |
| src_en | input | N_SRC | Enable bit for each SRC pair |
| src_req0_mask | input | N_SRC | 1 = the SRC pair obeys CLKREQ#0 |
| src_req1_mask | input | N_SRC | 1 = the SRC pair obeys CLKREQ#1 |
| req_tri | input | 1 | 1 = SRC pairs halted by CLKREQ# are tri-stated |
| src_pd_tri | input | 1 | 1 = SRC and SRCS pairs are tri-stated in power-down |
| srcs_en | input | N_SRCS | Enable bit for each SRCS pair |
| se_en | input | N_SE | Enable bit for each single-ended output |
| cpu_stop_n | input | 1 | Asynchronous CPU stop pin, active low |
| clkreq_n | input | 2 | Asynchronous CLKREQ# pins; 1 requests a stop |
| pd_req | input | 1 | Synchronous power-down request, active high |
| out_tick | input | N_CPU+N_SRC+N_SRCS+N_SE | Clock-low boundary pulse of each output. Index order: CPU, then SRC, then SRCS, then single-ended |
| out_run | output | N_CPU+N_SRC+N_SRCS+N_SE | 1 = the output toggles (same index order) |
| out_oe | output | N_CPU+N_SRC+N_SRCS+N_SE | 1 = the output pad is driven (same index order) |

## Verification
The bench builds the block with its default parameters: three CPU pairs, six SRC pairs, two SRCS pairs, three single-ended outputs and a CPU stop delay of two ticks. With a delay of two, the bench can observe the tick at which a stoppable pair still runs after the stop and the tick at which it halts. With two CLKREQ# pins and distinct SRC masks, it can show that each pin stops only the pairs that opted in to it. Letting the CPU stop count run out during power-down sets up the case where a stop beats a cleared enable bit once power-down ends.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;

  typedef struct packed {
    logic run;
    logic oe;
  } drive_t;

  // Priority: power-down, then stop, then static enable.
  function automatic drive_t pick_drive(input logic pd, input logic pd_tri,
                                        input logic stop, input logic stop_tri,
                                        input logic en, input logic diff);
    drive_t d;
    if (pd) begin
      d.run = 1'b0;
      d.oe  = ~pd_tri;
    end else if (stop) begin
      d.run = 1'b0;
      d.oe  = ~stop_tri;
    end else if (!en) begin
      d.run = 1'b0;
      d.oe  = ~diff;
    end else begin
      d.run = 1'b1;
      d.oe  = 1'b1;
    end
    return d;
  endfunction

endpackage

// File: rtl/clkout_sync2.sv
module clkout_sync2 #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= d;
      stable_q <= meta_q;
    end
  end

  assign q = stable_q;

  // The second stage only ever takes what the first stage held one cycle earlier.
  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stable_q == $past(meta_q))); // R13
endmodule

// File: rtl/clkout_slice.sv
module clkout_slice
  import clkout_gate_pkg::*;
#(
  parameter int STOP_TICKS = 0,
  parameter bit DIFF       = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic stop_req,
  input  logic stop_tri,
  input  logic pd,
  input  logic pd_tri,
  output logic run,
  output logic oe
);
  drive_t st_q, st_d;
  logic   stop_due;

  generate
    if (STOP_TICKS == 0) begin : g_nodelay
      assign stop_due = stop_req;
    end else begin : g_delay
      localparam int CW = $clog2(STOP_TICKS + 1);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (!stop_req)
          cnt_d = '0;
        else if (tick && (cnt_q != CW'(STOP_TICKS)))
          cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign stop_due = stop_req && (cnt_d == CW'(STOP_TICKS));

      if (STOP_TICKS > 1) begin : g_first_tick
        // A stop that is fresh at a tick must not halt a running output yet.
        AST_STOP_FIRST_TICK_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
          (tick && stop_req && (cnt_q == '0) && !pd && en) |=> run); // R5
      end
    end
  endgenerate

  always_comb begin
    st_d = st_q;
    if (tick)
      st_d = pick_drive(pd, pd_tri, stop_due, stop_tri, en, DIFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign run = st_q.run;
  assign oe  = st_q.oe;

  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(run) && $stable(oe))); // R3
  AST_RUN_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> oe); // R2
  AST_PD_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pd) |=> !run); // R11
  AST_PD_OE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pd) |=> (oe != $past(pd_tri))); // R11
  AST_DISABLED_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !en) |=> !run); // R4
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl #(
  parameter int N_CPU          = 3,
  parameter int N_SRC          = 6,
  parameter int N_SRCS         = 2,
  parameter int N_SE           = 3,
  parameter int CPU_STOP_TICKS = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [N_CPU-1:0]                    cpu_en,
  input  logic [N_CPU-1:0]                    cpu_stop_mask,
  input  logic                                cpu_stop_tri,
  input  logic                                cpu_pd_tri,
  input  logic [N_SRC-1:0]                    src_en,
  input  logic [N_SRC-1:0]                    src_req0_mask,
  input  logic [N_SRC-1:0]                    src_req1_mask,
  input  logic                                req_tri,
  input  logic                                src_pd_tri,
  input  logic [N_SRCS-1:0]                   srcs_en,
  input  logic [N_SE-1:0]                     se_en,
  input  logic                                cpu_stop_n,
  input  logic [1:0]                          clkreq_n,
  input  logic                                pd_req,
  input  logic [N_CPU+N_SRC+N_SRCS+N_SE-1:0]  out_tick,
  output logic [N_CPU+N_SRC+N_SRCS+N_SE-1:0]  out_run,
  output logic [N_CPU+N_SRC+N_SRCS+N_SE-1:0]  out_oe
);
  localparam int SRC_BASE  = N_CPU;
  localparam int SRCS_BASE = SRC_BASE + N_SRC;
  localparam int SE_BASE   = SRCS_BASE + N_SRCS;

  logic [2:0] pin_s;
  logic       cpu_stop_s;
  logic [1:0] req_s;

  clkout_sync2 #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({clkreq_n, ~cpu_stop_n}),
    .q     (pin_s)
  );

  assign cpu_stop_s = pin_s[0];
  assign req_s      = pin_s[2:1];

  generate
    for (genvar k = 0; k < N_CPU; k++) begin : g_cpu
      clkout_slice #(.STOP_TICKS(CPU_STOP_TICKS), .DIFF(1'b1)) u_slice (
        .clk(clk), .rst_n(rst_n), .tick(out_tick[k]), .en(cpu_en[k]),
        .stop_req(cpu_stop_mask[k] & cpu_stop_s), .stop_tri(cpu_stop_tri),
        .pd(pd_req), .pd_tri(cpu_pd_tri),
        .run(out_run[k]), .oe(out_oe[k]));
    end
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      clkout_slice #(.STOP_TICKS(0), .DIFF(1'b1)) u_slice (
        .clk(clk), .rst_n(rst_n), .tick(out_tick[SRC_BASE+i]), .en(src_en[i]),
        .stop_req((src_req0_mask[i] & req_s[0]) | (src_req1_mask[i] & req_s[1])),
        .stop_tri(req_tri), .pd(pd_req), .pd_tri(src_pd_tri),
        .run(out_run[SRC_BASE+i]), .oe(out_oe[SRC_BASE+i]));
    end
    for (genvar j = 0; j < N_SRCS; j++) begin : g_srcs
      clkout_slice #(.STOP_TICKS(0), .DIFF(1'b1)) u_slice (
        .clk(clk), .rst_n(rst_n), .tick(out_tick[SRCS_BASE+j]), .en(srcs_en[j]),
        .stop_req(1'b0), .stop_tri(1'b0), .pd(pd_req), .pd_tri(src_pd_tri),
        .run(out_run[SRCS_BASE+j]), .oe(out_oe[SRCS_BASE+j]));
    end
    for (genvar m = 0; m < N_SE; m++) begin : g_se
      clkout_slice #(.STOP_TICKS(0), .DIFF(1'b0)) u_slice (
        .clk(clk), .rst_n(rst_n), .tick(out_tick[SE_BASE+m]), .en(se_en[m]),
        .stop_req(1'b0), .stop_tri(1'b0), .pd(pd_req), .pd_tri(1'b0),
        .run(out_run[SE_BASE+m]), .oe(out_oe[SE_BASE+m]));
    end
  endgenerate

  // Outputs that no stop pin can reach stay driven whenever they run or power-down is absent.
  AST_SE_NEVER_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tick[SE_BASE] && se_en[0]) |=> out_oe[SE_BASE]); // R4
  AST_SRCS_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tick[SRCS_BASE] && srcs_en[0] && !pd_req) |=> out_run[SRCS_BASE]); // R8
endmodule

// File: tb/test_clkout_gate_ctrl.sv
module test_clkout_gate_ctrl;
  localparam int N_CPU = 3, N_SRC = 6, N_SRCS = 2, N_SE = 3;
  localparam int N_OUT = N_CPU + N_SRC + N_SRCS + N_SE;
  localparam int SRC0  = N_CPU;
  localparam int SRCS0 = N_CPU + N_SRC;
  localparam int SE0   = SRCS0 + N_SRCS;

  logic clk = 1'b0;
  logic rst_n;
  logic [N_CPU-1:0] cpu_en, cpu_stop_mask;
  logic cpu_stop_tri, cpu_pd_tri, req_tri, src_pd_tri;
  logic [N_SRC-1:0] src_en, src_req0_mask, src_req1_mask;
  logic [N_SRCS-1:0] srcs_en;
  logic [N_SE-1:0] se_en;
  logic cpu_stop_n, pd_req;
  logic [1:0] clkreq_n;
  logic [N_OUT-1:0] out_tick, out_run, out_oe;

  always #2.5 clk = ~clk;

  clkout_gate_ctrl i_clkout_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_stop_mask(cpu_stop_mask),
    .cpu_stop_tri(cpu_stop_tri), .cpu_pd_tri(cpu_pd_tri), .src_en(src_en),
    .src_req0_mask(src_req0_mask), .src_req1_mask(src_req1_mask), .req_tri(req_tri),
    .src_pd_tri(src_pd_tri), .srcs_en(srcs_en), .se_en(se_en), .cpu_stop_n(cpu_stop_n),
    .clkreq_n(clkreq_n), .pd_req(pd_req), .out_tick(out_tick),
    .out_run(out_run), .out_oe(out_oe));

  typedef struct {
    int    idx;
    logic  run;
    logic  oe;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Monitor: compares queued expectations one step after each rising edge.
  always begin
    exp_t e;
    @(posedge clk);
    #1;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if (out_run[e.idx] !== e.run || out_oe[e.idx] !== e.oe) begin
        fails++;
        $display("FAIL %s out %0d: run/oe actual %b/%b expected %b/%b",
                 e.tag, e.idx, out_run[e.idx], out_oe[e.idx], e.run, e.oe);
      end
    end
  end

  task automatic expect_out(input int idx, input logic r, input logic o, input string tag);
    exp_t e;
    e.idx = idx; e.run = r; e.oe = o; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    @(posedge clk);
    #2;
  endtask

  task automatic tick_once();
    @(negedge clk);
    out_tick = '1;
    @(negedge clk);
    out_tick = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cpu_en = '1; cpu_stop_mask = '1; cpu_stop_tri = 1'b0; cpu_pd_tri = 1'b0;
    src_en = '1; src_req0_mask = '0; src_req1_mask = '0; req_tri = 1'b1; src_pd_tri = 1'b1;
    srcs_en = '1; se_en = '1; cpu_stop_n = 1'b1; clkreq_n = 2'b00; pd_req = 1'b0;
    out_tick = '0;
    settle(4);
    rst_n = 1'b1;
    settle(2);
    for (int i = 0; i < N_OUT; i++) expect_out(i, 1'b0, 1'b0, "R1 reset quiet");
    drain();

    tick_once();
    for (int i = 0; i < N_OUT; i++) expect_out(i, 1'b1, 1'b1, "R2 enabled runs");
    drain();

    // R3 / R4: enable changes wait for a tick
    cpu_en[0] = 1'b0; se_en[0] = 1'b0; src_en[1] = 1'b0;
    settle(3);
    expect_out(0, 1'b1, 1'b1, "R3 no tick no change");
    drain();
    tick_once();
    expect_out(0, 1'b0, 1'b0, "R4 disabled CPU tri");
    expect_out(SRC0 + 1, 1'b0, 1'b0, "R4 disabled SRC tri");
    expect_out(SE0, 1'b0, 1'b1, "R4 disabled single-ended driven low");
    drain();
    cpu_en = '1; se_en = '1; src_en = '1;
    tick_once();
    expect_out(0, 1'b1, 1'b1, "R2 re-enabled");
    drain();

    // R5 / R6 / R7 / R10: CPU stop
    cpu_stop_mask = 3'b011;
    cpu_stop_n = 1'b0;
    settle(3);
    tick_once();
    expect_out(0, 1'b1, 1'b1, "R5 first tick still runs");
    drain();
    tick_once();
    expect_out(0, 1'b0, 1'b1, "R5 R7 halted at second tick, driven");
    expect_out(1, 1'b0, 1'b1, "R5 second stoppable pair halted");
    expect_out(2, 1'b1, 1'b1, "R6 unmasked CPU free runs");
    expect_out(SRC0, 1'b1, 1'b1, "R8 SRC unaffected by CPU stop");
    drain();
    cpu_stop_tri = 1'b1;
    tick_once();
    expect_out(0, 1'b0, 1'b0, "R7 stopped CPU tri-stated");
    drain();
    cpu_stop_n = 1'b1;
    settle(3);
    tick_once();
    expect_out(0, 1'b1, 1'b1, "R10 CPU resumes");
    drain();
    cpu_stop_tri = 1'b0;

    // R13 / R8 / R9 / R10: CLKREQ
    src_req0_mask = 6'b000001; src_req1_mask = 6'b000010;
    @(negedge clk);
    clkreq_n[0] = 1'b1;
    out_tick = '1;
    @(negedge clk);
    out_tick = '0;
    expect_out(SRC0, 1'b1, 1'b1, "R13 pin not seen after one flop");
    drain();
    settle(2);
    tick_once();
    expect_out(SRC0, 1'b0, 1'b0, "R8 R9 masked SRC stopped tri");
    expect_out(SRC0 + 1, 1'b1, 1'b1, "R8 other pin mask runs");
    expect_out(SRCS0, 1'b1, 1'b1, "R8 SRCS ignores pins");
    expect_out(SE0, 1'b1, 1'b1, "R8 single-ended ignores pins");
    drain();
    req_tri = 1'b0;
    clkreq_n[1] = 1'b1;
    settle(3);
    tick_once();
    expect_out(SRC0, 1'b0, 1'b1, "R9 stopped SRC driven");
    expect_out(SRC0 + 1, 1'b0, 1'b1, "R8 second pin stops its pair");
    expect_out(SRC0 + 2, 1'b1, 1'b1, "R8 unmasked SRC runs");
    drain();
    clkreq_n = 2'b00;
    settle(3);
    tick_once();
    expect_out(SRC0, 1'b1, 1'b1, "R10 SRC resumes");
    expect_out(SRC0 + 1, 1'b1, 1'b1, "R10 SRC resumes");
    drain();
    req_tri = 1'b1;

    // R11 / R12: power-down
    cpu_stop_n = 1'b0; cpu_stop_tri = 1'b1; pd_req = 1'b1;
    settle(3);
    tick_once();
    expect_out(0, 1'b0, 1'b1, "R12 R11 power-down mode beats stop mode");
    expect_out(SRC0, 1'b0, 1'b0, "R11 SRC tri in power-down");
    expect_out(SRCS0, 1'b0, 1'b0, "R11 SRCS tri in power-down");
    expect_out(SE0, 1'b0, 1'b1, "R11 single-ended driven low");
    expect_out(2, 1'b0, 1'b1, "R11 free-running CPU halts");
    drain();
    cpu_pd_tri = 1'b1; src_pd_tri = 1'b0;
    tick_once();
    expect_out(0, 1'b0, 1'b0, "R11 CPU tri in power-down");
    expect_out(SRC0, 1'b0, 1'b1, "R11 SRC driven in power-down");
    drain();
    pd_req = 1'b0; cpu_pd_tri = 1'b0; src_pd_tri = 1'b1; cpu_stop_tri = 1'b0;
    cpu_en[1] = 1'b0;
    tick_once();
    expect_out(1, 1'b0, 1'b1, "R12 stop mode beats disable");
    expect_out(2, 1'b1, 1'b1, "R6 free CPU back after power-down");
    expect_out(SRC0, 1'b1, 1'b1, "R11 SRC back after power-down");
    drain();

    cpu_stop_n = 1'b1; cpu_en = '1;
    settle(3);
    tick_once();
    expect_out(1, 1'b1, 1'b1, "R10 CPU resumes after stop");
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule